// File: doc/BRIEF.md
# DRAM Command Timing Guard

This block observes the command bus of a four-bank double-data-rate DRAM, sampling on every rising clock edge. It turns the active-low chip-select, row-strobe, column-strobe and write-enable pins into a command code. For each bank it records whether a row is open and which row that is. It also keeps the cycle counts needed to judge whether each command arrives too early for the bank it targets, or for the device as a whole.

The guard is placed beside a memory controller or a bus model as a passive monitor. Any command that breaks bank state or a spacing rule raises `viol_o` together with a one-hot code. The code is raised combinationally in the same cycle as the offending command. All limits are whole-cycle parameters. The defaults correspond to a 5 ns clock and a burst of two clocks.

A command that breaks a bank-state rule is discarded by the tracker. A command that only breaks a timing rule is still applied, as the device would act on it.

Top module: `dram_cmd_guard`

## Requirements
- R1: Pins {cs_n,ras_n,cas_n,we_n} decode to `cmd_o`. The patterns are: 0111 NOP=0, 0011 ACT=1, 0101 RD=2, 0100 WR=3, 0010 PRE=4, 0001 REF=5, 0000 MRS=6, 0110 burst stop=7. With cs_n high, the result is NOP and the bank state does not change.
- R2: An ACT to a closed bank sets that bank's bit in `bank_open_o` in the next cycle and stores `addr` as its row in `open_row_o` (bank i at bits i*ROW_W). Other banks are not affected. After reset no bank is open.
- R3: An RD or WR to a closed bank, or an ACT to an open bank, raises code bit 0 (0x01). Such a command changes neither the open flag nor the stored row.
- R4: An RD or WR issued fewer than T_RCD (4) cycles after the ACT of that bank raises bit 2 (0x04).
- R5: An ACT issued fewer than T_RP (4) cycles after a precharge of that bank raises bit 3 (0x08).
- R6: A precharge that closes a bank fewer than T_RAS_MIN (9) cycles after its ACT, or more than T_RAS_MAX (24000) cycles after it, raises bit 6 (0x40).
- R7: An ACT issued fewer than T_RC (12) cycles after the previous ACT of the same bank raises bit 4 (0x10).
- R8: An ACT issued fewer than T_RRD (3) cycles after an ACT to any bank raises bit 5 (0x20).
- R9: Bit 7 (0x80) is raised in two cases. The first is a precharge that closes a bank fewer than BURST_CYC+T_WR (5) cycles after a WR to it. The second is an RD fewer than BURST_CYC+T_WTR (3) cycles after any WR.
- R10: A PRE with addr[10]=1 closes every bank. A PRE with addr[10]=0 closes only the bank on `ba`.
- R11: An RD or WR with addr[10]=1 closes its bank in the next cycle. A later ACT to that bank raises bit 3 unless it comes at least BURST_CYC+T_RP (6) cycles after the read, or BURST_CYC+T_WR+T_RP (9) cycles after the write.
- R12: Any command other than NOP issued fewer than T_MRD (2) cycles after an MRS raises bit 1 (0x02).
- R13: `viol_code_o` carries at most one set bit, and the lowest-numbered violated rule wins. `viol_o` is high exactly when the code is non-zero. NOP cycles never carry a code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BANK_W | Bank address |
| addr | input | ROW_W | Row address; bit AP_BIT is the all-bank / auto-close flag |
| cmd_o | output | 3 | Decoded command code |
| bank_open_o | output | NUM_BANKS | One bit per bank, high while a row is open |
| open_row_o | output | NUM_BANKS*ROW_W | Stored row of each bank |
| viol_o | output | 1 | High in the cycle of a violating command |
| viol_code_o | output | 8 | One-hot violation code |

## Verification
Each spacing rule is probed with a command placed one cycle short of its limit and another placed exactly on the limit. This separates off-by-one counter loads from correct ones. Auto-close reads and writes are followed by activates at different distances, which tells the read reopen time from the write reopen time. All-bank and single-bank precharges are applied over a mix of open banks. Commands that break several rules at once, such as a repeated activate one cycle later, show whether the priority ordering picks the bank-state code.

// File: rtl/dram_guard_pkg.sv
`timescale 1ns/1ps
package dram_guard_pkg;
   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_ACT = 3'd1,
      CMD_RD  = 3'd2,
      CMD_WR  = 3'd3,
      CMD_PRE = 3'd4,
      CMD_REF = 3'd5,
      CMD_MRS = 3'd6,
      CMD_BST = 3'd7
   } cmd_e;

   localparam int VCODE_W  = 8;
   localparam int VB_STATE = 0;
   localparam int VB_MRD   = 1;
   localparam int VB_RCD   = 2;
   localparam int VB_RP    = 3;
   localparam int VB_RC    = 4;
   localparam int VB_RRD   = 5;
   localparam int VB_RAS   = 6;
   localparam int VB_WRITE = 7;
endpackage

// File: rtl/guard_decode.sv
`timescale 1ns/1ps
module guard_decode
   import dram_guard_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd
);
   always_comb begin
      if (cs_n) begin
         cmd = CMD_NOP;
      end else begin
         unique case ({ras_n, cas_n, we_n})
            3'b011:  cmd = CMD_ACT;
            3'b101:  cmd = CMD_RD;
            3'b100:  cmd = CMD_WR;
            3'b010:  cmd = CMD_PRE;
            3'b001:  cmd = CMD_REF;
            3'b000:  cmd = CMD_MRS;
            3'b110:  cmd = CMD_BST;
            default: cmd = CMD_NOP;
         endcase
      end
   end
endmodule

// File: rtl/guard_bank.sv
`timescale 1ns/1ps
module guard_bank
   import dram_guard_pkg::*;
#(
   parameter int ROW_W     = 13,
   parameter int CW        = 5,
   parameter int AW        = 15,
   parameter int T_RCD     = 4,
   parameter int T_RP      = 4,
   parameter int T_RAS_MIN = 9,
   parameter int T_RAS_MAX = 24000,
   parameter int T_RC      = 12,
   parameter int T_WR      = 3,
   parameter int BURST_CYC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,
   input  cmd_e             cmd,
   input  logic             flag10,
   input  logic [ROW_W-1:0] row_i,
   output logic             open_o,
   output logic [ROW_W-1:0] row_o,
   output logic             v_state,
   output logic             v_rcd,
   output logic             v_rp,
   output logic             v_ras,
   output logic             v_rc,
   output logic             v_wr
);
   localparam logic [CW-1:0] L_RCD = CW'(T_RCD - 1);
   localparam logic [CW-1:0] L_RAS = CW'(T_RAS_MIN - 1);
   localparam logic [CW-1:0] L_RC  = CW'(T_RC - 1);
   localparam logic [CW-1:0] L_RP  = CW'(T_RP - 1);
   localparam logic [CW-1:0] L_WR  = CW'(BURST_CYC + T_WR - 1);
   localparam logic [CW-1:0] L_APR = CW'(BURST_CYC + T_RP - 1);
   localparam logic [CW-1:0] L_APW = CW'(BURST_CYC + T_WR + T_RP - 1);
   localparam logic [AW-1:0] AGE_MAX = AW'(T_RAS_MAX);
   localparam logic [AW-1:0] AGE_TOP = AW'(T_RAS_MAX + 1);

   logic [CW-1:0] rcd_c, ras_c, rc_c, rp_c, wr_c;
   logic [AW-1:0] age;
   logic          is_act, is_acc, is_pre, closes, do_act, do_acc, ap_close;

   function automatic logic [CW-1:0] dn(input logic [CW-1:0] v);
      return (v == '0) ? v : v - 1'b1;
   endfunction

   assign is_act   = (cmd == CMD_ACT);
   assign is_acc   = (cmd == CMD_RD) || (cmd == CMD_WR);
   assign is_pre   = (cmd == CMD_PRE);
   assign closes   = is_pre && (flag10 || hit) && open_o;
   assign do_act   = hit && is_act && !open_o;
   assign do_acc   = hit && is_acc && open_o;
   assign ap_close = do_acc && flag10;

   assign v_state = hit && ((is_act && open_o) || (is_acc && !open_o));
   assign v_rcd   = do_acc && (rcd_c != '0);
   assign v_rp    = do_act && (rp_c != '0);
   assign v_rc    = do_act && (rc_c != '0);
   assign v_ras   = closes && ((ras_c != '0) || (age > AGE_MAX));
   assign v_wr    = closes && (wr_c != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_o <= 1'b0;
         row_o  <= '0;
         rcd_c  <= '0;
         ras_c  <= '0;
         rc_c   <= '0;
         rp_c   <= '0;
         wr_c   <= '0;
         age    <= '0;
      end else begin
         if (do_act) begin
            open_o <= 1'b1;
            row_o  <= row_i;
         end else if (closes || ap_close) begin
            open_o <= 1'b0;
         end
         rcd_c <= do_act ? L_RCD : dn(rcd_c);
         ras_c <= do_act ? L_RAS : dn(ras_c);
         rc_c  <= do_act ? L_RC  : dn(rc_c);
         if (closes)
            rp_c <= L_RP;
         else if (ap_close)
            rp_c <= (cmd == CMD_WR) ? L_APW : L_APR;
         else
            rp_c <= dn(rp_c);
         wr_c <= (do_acc && cmd == CMD_WR) ? L_WR : dn(wr_c);
         if (do_act)
            age <= AW'(1);
         else if (open_o && age != AGE_TOP)
            age <= age + 1'b1;
      end
   end
endmodule

// File: rtl/guard_shared.sv
`timescale 1ns/1ps
module guard_shared
   import dram_guard_pkg::*;
#(
   parameter int CW        = 5,
   parameter int T_RRD     = 3,
   parameter int T_WTR     = 1,
   parameter int T_MRD     = 2,
   parameter int BURST_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  cmd_e cmd,
   input  logic commit,
   output logic v_rrd,
   output logic v_wtr,
   output logic v_mrd
);
   localparam logic [CW-1:0] L_RRD = CW'(T_RRD - 1);
   localparam logic [CW-1:0] L_WTR = CW'(BURST_CYC + T_WTR - 1);
   localparam logic [CW-1:0] L_MRD = CW'(T_MRD - 1);

   logic [CW-1:0] rrd_c, wtr_c, mrd_c;

   function automatic logic [CW-1:0] dn(input logic [CW-1:0] v);
      return (v == '0) ? v : v - 1'b1;
   endfunction

   assign v_rrd = (cmd == CMD_ACT) && (rrd_c != '0);
   assign v_wtr = (cmd == CMD_RD)  && (wtr_c != '0);
   assign v_mrd = (cmd != CMD_NOP) && (mrd_c != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rrd_c <= '0;
         wtr_c <= '0;
         mrd_c <= '0;
      end else begin
         rrd_c <= (commit && cmd == CMD_ACT) ? L_RRD : dn(rrd_c);
         wtr_c <= (commit && cmd == CMD_WR)  ? L_WTR : dn(wtr_c);
         mrd_c <= (commit && cmd == CMD_MRS) ? L_MRD : dn(mrd_c);
      end
   end
endmodule

// File: rtl/dram_cmd_guard.sv
`timescale 1ns/1ps
module dram_cmd_guard
   import dram_guard_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int BANK_W    = 2,
   parameter int ROW_W     = 13,
   parameter int AP_BIT    = 10,
   parameter int T_RCD     = 4,
   parameter int T_RP      = 4,
   parameter int T_RAS_MIN = 9,
   parameter int T_RAS_MAX = 24000,
   parameter int T_RC      = 12,
   parameter int T_RRD     = 3,
   parameter int T_WR      = 3,
   parameter int T_WTR     = 1,
   parameter int T_MRD     = 2,
   parameter int BURST_CYC = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cs_n,
   input  logic                       ras_n,
   input  logic                       cas_n,
   input  logic                       we_n,
   input  logic [BANK_W-1:0]          ba,
   input  logic [ROW_W-1:0]           addr,
   output logic [2:0]                 cmd_o,
   output logic [NUM_BANKS-1:0]       bank_open_o,
   output logic [NUM_BANKS*ROW_W-1:0] open_row_o,
   output logic                       viol_o,
   output logic [VCODE_W-1:0]         viol_code_o
);
   localparam int CW = $clog2(T_RC + T_RRD + BURST_CYC + T_WR + T_WTR + T_MRD + T_RP + 1);
   localparam int AW = $clog2(T_RAS_MAX + 2);

   if (NUM_BANKS != (1 << BANK_W)) begin : g_bad_banks
      $error("NUM_BANKS must equal 2**BANK_W");
   end
   if (AP_BIT >= ROW_W) begin : g_bad_ap
      $error("AP_BIT must lie inside the address bus");
   end
   if (T_RCD < 1 || T_RP < 1 || T_RRD < 1 || T_MRD < 1 || BURST_CYC < 1) begin : g_bad_time
      $error("timing limits must be at least one cycle");
   end
   if (T_RC < T_RRD || T_RAS_MAX < T_RAS_MIN) begin : g_bad_order
      $error("inconsistent timing limits");
   end

   cmd_e                 cmd;
   logic                 flag10;
   logic [NUM_BANKS-1:0] b_state, b_rcd, b_rp, b_ras, b_rc, b_wr;
   logic                 s_rrd, s_wtr, s_mrd, commit;
   logic [VCODE_W-1:0]   raw;

   assign flag10 = addr[AP_BIT];

   guard_decode u_dec (
      .cs_n (cs_n),
      .ras_n(ras_n),
      .cas_n(cas_n),
      .we_n (we_n),
      .cmd  (cmd)
   );

   for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
      logic             hit_i;
      logic [ROW_W-1:0] row_i_q;
      assign hit_i = (ba == BANK_W'(i));
      guard_bank #(
         .ROW_W(ROW_W), .CW(CW), .AW(AW),
         .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS_MIN(T_RAS_MIN), .T_RAS_MAX(T_RAS_MAX),
         .T_RC(T_RC), .T_WR(T_WR), .BURST_CYC(BURST_CYC)
      ) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .hit    (hit_i),
         .cmd    (cmd),
         .flag10 (flag10),
         .row_i  (addr),
         .open_o (bank_open_o[i]),
         .row_o  (row_i_q),
         .v_state(b_state[i]),
         .v_rcd  (b_rcd[i]),
         .v_rp   (b_rp[i]),
         .v_ras  (b_ras[i]),
         .v_rc   (b_rc[i]),
         .v_wr   (b_wr[i])
      );
      assign open_row_o[i*ROW_W +: ROW_W] = row_i_q;
   end

   assign commit = ~|b_state;

   guard_shared #(
      .CW(CW), .T_RRD(T_RRD), .T_WTR(T_WTR), .T_MRD(T_MRD), .BURST_CYC(BURST_CYC)
   ) u_shared (
      .clk   (clk),
      .rst_n (rst_n),
      .cmd   (cmd),
      .commit(commit),
      .v_rrd (s_rrd),
      .v_wtr (s_wtr),
      .v_mrd (s_mrd)
   );

   always_comb begin
      raw           = '0;
      raw[VB_STATE] = |b_state;
      raw[VB_MRD]   = s_mrd;
      raw[VB_RCD]   = |b_rcd;
      raw[VB_RP]    = |b_rp;
      raw[VB_RC]    = |b_rc;
      raw[VB_RRD]   = s_rrd;
      raw[VB_RAS]   = |b_ras;
      raw[VB_WRITE] = (|b_wr) | s_wtr;
   end

   assign viol_code_o = raw & (~raw + VCODE_W'(1));
   assign viol_o      = |raw;
   assign cmd_o       = cmd;
endmodule

// File: rtl/guard_checker.sv
`timescale 1ns/1ps
module guard_checker #(
   parameter int NB     = 4,
   parameter int BANK_W = 2,
   parameter int ROW_W  = 13,
   parameter int AP_BIT = 10
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cs_n,
   input logic                ras_n,
   input logic                cas_n,
   input logic                we_n,
   input logic [BANK_W-1:0]   ba,
   input logic [ROW_W-1:0]    addr,
   input logic [2:0]          cmd_o,
   input logic [NB-1:0]       bank_open_o,
   input logic [NB*ROW_W-1:0] open_row_o,
   input logic                viol_o,
   input logic [7:0]          viol_code_o
);
   localparam logic [2:0] C_NOP = 3'd0;
   localparam logic [2:0] C_ACT = 3'd1;
   localparam logic [2:0] C_RD  = 3'd2;

   logic pin_pre;
   assign pin_pre = !cs_n && !ras_n && cas_n && !we_n;

   a_r13_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(viol_code_o) && (viol_o == (viol_code_o != 8'd0)));

   a_r13_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == C_NOP) |-> (viol_code_o == 8'd0));

   a_r1_cs_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> ($stable(bank_open_o) && $stable(open_row_o)));

   a_r10_all_close: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_pre && addr[AP_BIT]) |=> (bank_open_o == '0));

   a_r3_closed_access: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == C_RD && !bank_open_o[ba]) |-> viol_code_o[0]);

   a_r2_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == C_ACT && !bank_open_o[ba]) |=> bank_open_o[$past(ba)]);
endmodule

bind dram_cmd_guard guard_checker #(
   .NB(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W), .AP_BIT(AP_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
   .ba(ba), .addr(addr), .cmd_o(cmd_o), .bank_open_o(bank_open_o),
   .open_row_o(open_row_o), .viol_o(viol_o), .viol_code_o(viol_code_o)
);

// File: tb/tb_dram_cmd_guard.sv
`timescale 1ns/1ps
module tb_dram_cmd_guard;
   localparam logic [3:0] P_NOP = 4'b0111, P_ACT = 4'b0011, P_RD = 4'b0101, P_WR = 4'b0100,
                          P_PRE = 4'b0010, P_REF = 4'b0001, P_MRS = 4'b0000, P_BST = 4'b0110;
   localparam logic [12:0] AP = 13'h0400;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0]  ba = '0;
   logic [12:0] addr = '0;
   logic [2:0]  cmd_o;
   logic [3:0]  bank_open_o;
   logic [51:0] open_row_o;
   logic        viol_o;
   logic [7:0]  viol_code_o;
   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   dram_cmd_guard dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .ba(ba), .addr(addr), .cmd_o(cmd_o), .bank_open_o(bank_open_o),
      .open_row_o(open_row_o), .viol_o(viol_o), .viol_code_o(viol_code_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [3:0] p, input int bank, input logic [12:0] a);
      @(negedge clk);
      {cs_n, ras_n, cas_n, we_n} = p;
      ba = 2'(bank);
      addr = a;
      #1;
   endtask

   task automatic nops(input int n);
      for (int i = 0; i < n; i++) issue(P_NOP, 0, '0);
   endtask

   task automatic cleanup();
      nops(20);
      issue(P_PRE, 0, AP);
      nops(20);
   endtask

   task automatic t_reset();
      issue(P_NOP, 0, '0);
      chk("R2 reset banks closed", bank_open_o, 4'b0000);
      chk("R13 reset no code", {viol_o, viol_code_o}, 9'h000);
   endtask

   task automatic t_decode();
      issue(4'b1011, 1, '0);
      chk("R1 cs high is nop", cmd_o, 3'd0);
      issue(P_NOP, 0, '0);
      chk("R1 cs high no open", bank_open_o, 4'b0000);
      issue(P_ACT, 0, '0); chk("R1 act", cmd_o, 3'd1);
      issue(P_RD,  0, '0); chk("R1 rd",  cmd_o, 3'd2);
      issue(P_WR,  0, '0); chk("R1 wr",  cmd_o, 3'd3);
      issue(P_PRE, 0, '0); chk("R1 pre", cmd_o, 3'd4);
      issue(P_REF, 0, '0); chk("R1 ref", cmd_o, 3'd5);
      issue(P_BST, 0, '0); chk("R1 bst", cmd_o, 3'd7);
      issue(P_MRS, 0, '0); chk("R1 mrs", cmd_o, 3'd6);
      issue(P_NOP, 0, '0); chk("R1 nop", cmd_o, 3'd0);
      cleanup();
   endtask

   task automatic t_open();
      issue(P_ACT, 2, 13'h1ABC);
      issue(P_NOP, 0, '0);
      chk("R2 bank2 open", bank_open_o, 4'b0100);
      chk("R2 bank2 row", open_row_o[26 +: 13], 13'h1ABC);
      nops(1);
      issue(P_ACT, 0, 13'h0123);
      issue(P_NOP, 0, '0);
      chk("R2 bank0 open too", bank_open_o, 4'b0101);
      chk("R2 bank0 row", open_row_o[0 +: 13], 13'h0123);
      chk("R2 bank2 row kept", open_row_o[26 +: 13], 13'h1ABC);
      cleanup();
      chk("R10 all closed", bank_open_o, 4'b0000);
   endtask

   task automatic t_state();
      issue(P_RD, 1, '0);
      chk("R3 read closed bank", viol_code_o, 8'h01);
      chk("R13 viol_o with code", viol_o, 1'b1);
      issue(P_ACT, 1, 13'h0005);
      nops(20);
      issue(P_ACT, 1, 13'h0007);
      chk("R3 act open bank", viol_code_o, 8'h01);
      issue(P_NOP, 0, '0);
      chk("R3 row unchanged", open_row_o[13 +: 13], 13'h0005);
      chk("R13 pulse ends", viol_code_o, 8'h00);
      cleanup();
   endtask

   task automatic t_prio();
      issue(P_ACT, 3, 13'h0009);
      issue(P_ACT, 3, 13'h000A);
      chk("R13 state wins over rc rrd", viol_code_o, 8'h01);
      cleanup();
   endtask

   task automatic t_rcd();
      issue(P_ACT, 0, '0);
      nops(2);
      issue(P_RD, 0, '0);
      chk("R4 rd at 3", viol_code_o, 8'h04);
      issue(P_RD, 0, '0);
      chk("R4 rd at 4", viol_code_o, 8'h00);
      cleanup();
   endtask

   task automatic t_ras();
      issue(P_ACT, 0, '0);
      nops(7);
      issue(P_PRE, 0, '0);
      chk("R6 pre at 8", viol_code_o, 8'h40);
      nops(20);
      issue(P_ACT, 0, '0);
      nops(8);
      issue(P_PRE, 0, '0);
      chk("R6 pre at 9", viol_code_o, 8'h00);
      cleanup();
   endtask

   task automatic t_rasmax();
      issue(P_ACT, 0, '0);
      nops(2);
      issue(P_ACT, 1, '0);
      nops(23996);
      issue(P_PRE, 0, '0);
      chk("R6 pre at max", viol_code_o, 8'h00);
      nops(3);
      issue(P_PRE, 1, '0);
      chk("R6 pre past max", viol_code_o, 8'h40);
      cleanup();
   endtask

   task automatic t_rp();
      issue(P_ACT, 3, '0);
      nops(19);
      issue(P_PRE, 3, '0);
      nops(2);
      issue(P_ACT, 3, '0);
      chk("R5 act 3 after pre", viol_code_o, 8'h08);
      nops(20);
      issue(P_PRE, 3, '0);
      nops(3);
      issue(P_ACT, 3, '0);
      chk("R5 act 4 after pre", viol_code_o, 8'h00);
      cleanup();
   endtask

   task automatic t_rc();
      issue(P_ACT, 1, '0);
      nops(3);
      issue(P_RD, 1, AP);
      chk("R11 rd auto close ok", viol_code_o, 8'h00);
      issue(P_NOP, 0, '0);
      chk("R11 rd auto close", bank_open_o[1], 1'b0);
      nops(4);
      issue(P_ACT, 1, '0);
      chk("R7 act 10 after act", viol_code_o, 8'h10);
      cleanup();
   endtask

   task automatic t_rrd();
      issue(P_ACT, 0, '0);
      nops(1);
      issue(P_ACT, 1, '0);
      chk("R8 act other bank at 2", viol_code_o, 8'h20);
      nops(2);
      issue(P_ACT, 2, '0);
      chk("R8 act other bank at 3", viol_code_o, 8'h00);
      cleanup();
   endtask

   task automatic t_write();
      issue(P_ACT, 0, '0);
      nops(4);
      issue(P_WR, 0, '0);
      nops(3);
      issue(P_PRE, 0, '0);
      chk("R9 pre 4 after wr", viol_code_o, 8'h80);
      nops(20);
      issue(P_ACT, 1, '0);
      nops(4);
      issue(P_WR, 1, '0);
      nops(4);
      issue(P_PRE, 1, '0);
      chk("R9 pre 5 after wr", viol_code_o, 8'h00);
      nops(20);
      issue(P_ACT, 2, '0);
      nops(4);
      issue(P_WR, 2, '0);
      nops(1);
      issue(P_RD, 2, '0);
      chk("R9 rd 2 after wr", viol_code_o, 8'h80);
      issue(P_RD, 2, '0);
      chk("R9 rd 3 after wr", viol_code_o, 8'h00);
      cleanup();
   endtask

   task automatic t_pall();
      issue(P_ACT, 0, '0);
      nops(2);
      issue(P_ACT, 2, '0);
      nops(2);
      issue(P_ACT, 1, '0);
      nops(20);
      issue(P_PRE, 1, '0);
      issue(P_NOP, 0, '0);
      chk("R10 single bank close", bank_open_o, 4'b0101);
      issue(P_PRE, 3, AP);
      issue(P_NOP, 0, '0);
      chk("R10 all bank close", bank_open_o, 4'b0000);
      cleanup();
   endtask

   task automatic t_wap();
      issue(P_ACT, 3, '0);
      nops(4);
      issue(P_WR, 3, AP);
      issue(P_NOP, 0, '0);
      chk("R11 wr auto close", bank_open_o[3], 1'b0);
      nops(6);
      issue(P_ACT, 3, '0);
      chk("R11 act 8 after wr ap", viol_code_o, 8'h08);
      nops(20);
      issue(P_ACT, 2, '0);
      nops(4);
      issue(P_WR, 2, AP);
      nops(8);
      issue(P_ACT, 2, '0);
      chk("R11 act 9 after wr ap", viol_code_o, 8'h00);
      cleanup();
   endtask

   task automatic t_mrd();
      issue(P_MRS, 0, '0);
      issue(P_REF, 0, '0);
      chk("R12 cmd 1 after mrs", viol_code_o, 8'h02);
      issue(P_REF, 0, '0);
      chk("R12 cmd 2 after mrs", viol_code_o, 8'h00);
      nops(5);
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      nops(3);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_decode();
      t_open();
      t_state();
      t_prio();
      t_rcd();
      t_ras();
      t_rp();
      t_rc();
      t_rrd();
      t_write();
      t_pall();
      t_wap();
      t_mrd();
      t_rasmax();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule